// File: doc/BRIEF.md
# SHA-256 Compression Core

This block applies the SHA-256 compression function to one 512-bit message block and a 256-bit chaining value. It runs the 64 rounds one per clock cycle and then adds the final working variables word by word to the chaining value. A caller pulses `start` with a block and a chaining value. Later it collects the digest, which is marked by a one-cycle `done`. The caller handles a longer message by feeding each result back as the next block's chaining value. Padding and message scheduling across blocks belong to the caller.

The message schedule lives in a 16-word window that shifts once per round and appends a newly expanded word at its tail. The round datapath does not add the `h` word and the round constant inside the round. It registers their sum one cycle early, while that word still sits in position `g`. This shortens the adder chain in each round. The round constants are decoded by combinational logic. No storage array is used for them.

Top module: `sha256_core`

## Requirements
- R1: Word order is big-endian by word. `block_in[511-32*i -: 32]` is message word W_i for i = 0..15. `hash_in[255-32*j -: 32]` is chaining word H_j for j = 0..7, where H_0 seeds working variable a and H_7 seeds h. `hash_out` uses the same order as `hash_in`.
- R2: `hash_out` equals the SHA-256 compression function of the captured block and chaining value. This covers the standard round and schedule functions, with all sums taken modulo 2^32 and the final word-wise feed-forward. The single block "abc" with the standard initial value gives ba7816bf...f20015ad.
- R3: The core can be chained. A first result fed back as `hash_in` with the second block gives the standard two-block digest 248d6a61...19db06c1 for the 56-character "abcdbcde...nopq" message.
- R4: `start` is accepted at a rising edge where it is high and the core is idle. If E is that edge, `done` is high during the cycle that follows edge E+65.
- R5: `done` stays high for exactly one cycle per accepted start.
- R6: `hash_out` keeps its value from one `done` to the next.
- R7: `block_in` and `hash_in` are captured only at acceptance. Changes on them while rounds are in progress do not affect the result or the timing. The same holds for `start` pulses during that time.
- R8: `rst_n` low at a rising edge returns the core to idle with `done` low and `hash_out` zero. An interrupted run never produces `done`.
- R9: A start that is high in the cycle where `done` is high is accepted, which allows back-to-back blocks with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to compress one block; taken only when idle |
| block_in | input | 512 | Message block, W_0 in the top word |
| hash_in | input | 256 | Chaining value, H_0 in the top word |
| done | output | 1 | One-cycle pulse marking a new `hash_out` |
| hash_out | output | 256 | Chaining value plus final working variables |

## Verification
The published "abc" vector checks the round, schedule and feed-forward arithmetic against a known digest. The chained two-block vector adds a check that one call's output works as the next call's input. Blocks and chaining values drawn at random are compared with a reference model in the bench, which exercises carries and rotations that the sparse standard blocks leave untouched. The bench changes the data inputs and pulses `start` during the rounds; a matching result shows that only the values captured at acceptance count. Back-to-back starts and a reset in the middle of a run test the edges of the control sequence.

// File: rtl/sha256_pkg.sv
// Package: shared sizes, control encoding and SHA-256 bit functions.
// Assumes 32-bit words as fixed by the algorithm; other sizes derive from it.
package sha256_pkg;
    localparam int WORD_W     = 32;
    localparam int BLK_WORDS  = 16;
    localparam int ST_WORDS   = 8;
    localparam int NUM_ROUNDS = 64;
    localparam int RND_W      = $clog2(NUM_ROUNDS);
    localparam int BLOCK_W    = WORD_W * BLK_WORDS;
    localparam int DIGEST_W   = WORD_W * ST_WORDS;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_ROUND = 2'd1,
        CTL_FINAL = 2'd2
    } ctl_e;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t pick(input word_t s, input word_t y, input word_t z);
        return (s & y) | (~s & z);
    endfunction

    function automatic word_t vote(input word_t x, input word_t y, input word_t z);
        return (x & y) | (x & z) | (y & z);
    endfunction
endpackage

// File: rtl/sha256_kconst.sv
// Round-constant decoder: maps a round index to its 32-bit constant.
// Pure combinational case logic so no storage array is inferred.
module sha256_kconst
    import sha256_pkg::*;
(
    input  logic [RND_W-1:0] idx,
    output word_t            kval
);
    // Decode the index into the constant.
    always_comb begin
        case (idx)
            6'd0:  kval = 32'h428a2f98;  6'd1:  kval = 32'h71374491;
            6'd2:  kval = 32'hb5c0fbcf;  6'd3:  kval = 32'he9b5dba5;
            6'd4:  kval = 32'h3956c25b;  6'd5:  kval = 32'h59f111f1;
            6'd6:  kval = 32'h923f82a4;  6'd7:  kval = 32'hab1c5ed5;
            6'd8:  kval = 32'hd807aa98;  6'd9:  kval = 32'h12835b01;
            6'd10: kval = 32'h243185be;  6'd11: kval = 32'h550c7dc3;
            6'd12: kval = 32'h72be5d74;  6'd13: kval = 32'h80deb1fe;
            6'd14: kval = 32'h9bdc06a7;  6'd15: kval = 32'hc19bf174;
            6'd16: kval = 32'he49b69c1;  6'd17: kval = 32'hefbe4786;
            6'd18: kval = 32'h0fc19dc6;  6'd19: kval = 32'h240ca1cc;
            6'd20: kval = 32'h2de92c6f;  6'd21: kval = 32'h4a7484aa;
            6'd22: kval = 32'h5cb0a9dc;  6'd23: kval = 32'h76f988da;
            6'd24: kval = 32'h983e5152;  6'd25: kval = 32'ha831c66d;
            6'd26: kval = 32'hb00327c8;  6'd27: kval = 32'hbf597fc7;
            6'd28: kval = 32'hc6e00bf3;  6'd29: kval = 32'hd5a79147;
            6'd30: kval = 32'h06ca6351;  6'd31: kval = 32'h14292967;
            6'd32: kval = 32'h27b70a85;  6'd33: kval = 32'h2e1b2138;
            6'd34: kval = 32'h4d2c6dfc;  6'd35: kval = 32'h53380d13;
            6'd36: kval = 32'h650a7354;  6'd37: kval = 32'h766a0abb;
            6'd38: kval = 32'h81c2c92e;  6'd39: kval = 32'h92722c85;
            6'd40: kval = 32'ha2bfe8a1;  6'd41: kval = 32'ha81a664b;
            6'd42: kval = 32'hc24b8b70;  6'd43: kval = 32'hc76c51a3;
            6'd44: kval = 32'hd192e819;  6'd45: kval = 32'hd6990624;
            6'd46: kval = 32'hf40e3585;  6'd47: kval = 32'h106aa070;
            6'd48: kval = 32'h19a4c116;  6'd49: kval = 32'h1e376c08;
            6'd50: kval = 32'h2748774c;  6'd51: kval = 32'h34b0bcb5;
            6'd52: kval = 32'h391c0cb3;  6'd53: kval = 32'h4ed8aa4a;
            6'd54: kval = 32'h5b9cca4f;  6'd55: kval = 32'h682e6ff3;
            6'd56: kval = 32'h748f82ee;  6'd57: kval = 32'h78a5636f;
            6'd58: kval = 32'h84c87814;  6'd59: kval = 32'h8cc70208;
            6'd60: kval = 32'h90befffa;  6'd61: kval = 32'ha4506ceb;
            6'd62: kval = 32'hbef9a3f7;  default: kval = 32'hc67178f2;
        endcase
    end
endmodule

// File: rtl/sha256_sched.sv
// Message schedule: a 16-word window of flops. The current round's word is
// entry 0. Each step shifts the window down one place and appends a newly
// expanded word at the tail. Assumes load and step are never high together.
module sha256_sched
    import sha256_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [BLOCK_W-1:0] block_in,
    output word_t              w_cur
);
    localparam int LAST = BLK_WORDS - 1;

    word_t win     [BLK_WORDS];
    word_t win_nxt [BLK_WORDS];
    word_t w_new;

    // Expand the next schedule word from the window taps.
    assign w_new = win[0] + small_sig0(win[1]) + win[9] + small_sig1(win[14]);
    assign w_cur = win[0];

    // Select the next value of each window entry.
    for (genvar i = 0; i < BLK_WORDS; i++) begin : g_win
        if (i < LAST) begin : g_mid
            assign win_nxt[i] = load ? block_in[BLOCK_W-1-WORD_W*i -: WORD_W]
                              : step ? win[i+1] : win[i];
        end else begin : g_tail
            assign win_nxt[i] = load ? block_in[BLOCK_W-1-WORD_W*i -: WORD_W]
                              : step ? w_new : win[i];
        end
    end

    // Update the window registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < BLK_WORDS; i++) begin
            if (!rst_n) win[i] <= '0;
            else        win[i] <= win_nxt[i];
        end
    end
endmodule

// File: rtl/sha256_round.sv
// Round datapath: holds the working variables a..h and a precomputed
// addend p. Register p is loaded with h+K[0] at load time and with g+K[t+1]
// in round t. In the next round that g has become h, so each round adds
// p in place of h+K. Assumes k_next carries K[0] during load and K[t+1]
// during round t.
module sha256_round
    import sha256_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [DIGEST_W-1:0] seed,
    input  word_t               w_cur,
    input  word_t               k_next,
    output logic [DIGEST_W-1:0] state
);
    word_t va, vb, vc, vd, ve, vf, vg;
    word_t p_q, t1, t2;
    logic [DIGEST_W-1:0] state_nxt;

    assign va = state[DIGEST_W-1-WORD_W*0 -: WORD_W];
    assign vb = state[DIGEST_W-1-WORD_W*1 -: WORD_W];
    assign vc = state[DIGEST_W-1-WORD_W*2 -: WORD_W];
    assign vd = state[DIGEST_W-1-WORD_W*3 -: WORD_W];
    assign ve = state[DIGEST_W-1-WORD_W*4 -: WORD_W];
    assign vf = state[DIGEST_W-1-WORD_W*5 -: WORD_W];
    assign vg = state[DIGEST_W-1-WORD_W*6 -: WORD_W];

    // Compute one round with the early h+K addend.
    always_comb begin
        t1        = pick(ve, vf, vg) + big_sig1(ve) + p_q + w_cur;
        t2        = big_sig0(va) + vote(va, vb, vc);
        state_nxt = {t1 + t2, va, vb, vc, vd + t1, ve, vf, vg};
    end

    // Update the working variables and the addend register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
            p_q   <= '0;
        end else if (load) begin
            state <= seed;
            p_q   <= seed[WORD_W-1:0] + k_next;
        end else if (step) begin
            state <= state_nxt;
            p_q   <= vg + k_next;
        end
    end
endmodule

// File: rtl/sha256_core.sv
// SHA-256 compression core. It accepts a block when idle, runs 64 rounds
// one per cycle, then adds the working variables to the captured chaining
// value and pulses done. While a run is in progress it ignores start and
// the data inputs. Reset is synchronous and active-low.
module sha256_core
    import sha256_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BLOCK_W-1:0]  block_in,
    input  logic [DIGEST_W-1:0] hash_in,
    output logic                done,
    output logic [DIGEST_W-1:0] hash_out
);
    localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS - 1);

    ctl_e                ctl;
    logic [RND_W-1:0]    rnd;
    logic [RND_W-1:0]    k_idx;
    logic [DIGEST_W-1:0] chain;
    logic [DIGEST_W-1:0] state;
    logic [DIGEST_W-1:0] digest_sum;
    logic                accept, step;
    word_t               w_cur, k_next;

    assign accept = (ctl == CTL_IDLE) && start;
    assign step   = (ctl == CTL_ROUND);
    assign k_idx  = (ctl == CTL_IDLE) ? '0 : rnd + 1'b1;

    sha256_kconst i_kconst (
        .idx  (k_idx),
        .kval (k_next)
    );

    sha256_sched i_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (step),
        .block_in (block_in),
        .w_cur    (w_cur)
    );

    sha256_round i_round (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (step),
        .seed   (hash_in),
        .w_cur  (w_cur),
        .k_next (k_next),
        .state  (state)
    );

    // Add the final working variables to the chaining value, one word at a time.
    for (genvar i = 0; i < ST_WORDS; i++) begin : g_ff
        assign digest_sum[WORD_W*i +: WORD_W] =
            state[WORD_W*i +: WORD_W] + chain[WORD_W*i +: WORD_W];
    end

    // Sequence idle, rounds and the final addition; drive done and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl      <= CTL_IDLE;
            rnd      <= '0;
            chain    <= '0;
            done     <= 1'b0;
            hash_out <= '0;
        end else begin
            done <= 1'b0;
            case (ctl)
                CTL_IDLE: begin
                    if (start) begin
                        ctl   <= CTL_ROUND;
                        rnd   <= '0;
                        chain <= hash_in;
                    end
                end
                CTL_ROUND: begin
                    rnd <= rnd + 1'b1;
                    if (rnd == RND_LAST) ctl <= CTL_FINAL;
                end
                CTL_FINAL: begin
                    hash_out <= digest_sum;
                    done     <= 1'b1;
                    ctl      <= CTL_IDLE;
                end
                default: ctl <= CTL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sha256_core_chk.sv
// Checker for sha256_core: timing and control properties. It is attached
// with bind and observes ports plus the control state and round counter.
module sha256_core_chk
    import sha256_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic [DIGEST_W-1:0] hash_out,
    input ctl_e                ctl,
    input logic [RND_W-1:0]    rnd
);
    localparam int LAT_W = RND_W + 2;
    localparam logic [LAT_W-1:0] LAT_EXP = LAT_W'(NUM_ROUNDS + 1);
    localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS - 1);

    logic             busy;
    logic [LAT_W-1:0] lat;

    assign busy = (ctl != CTL_IDLE);

    // Count edges since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)              lat <= '0;
        else if (start && !busy) lat <= '0;
        else if (busy)           lat <= lat + 1'b1;
    end

    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (ctl == CTL_ROUND && rnd == '0));

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == LAT_EXP && !busy));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(hash_out));

    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_ROUND && start && rnd != RND_LAST)
            |=> (ctl == CTL_ROUND && rnd == $past(rnd) + 1'b1));
endmodule

bind sha256_core sha256_core_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .hash_out (hash_out),
    .ctl      (ctl),
    .rnd      (rnd)
);

// File: tb/test_sha256_core.sv
`timescale 1ns/1ps
// Bench for sha256_core: standard vectors, seeded random blocks compared
// with a reference compression model, and control corner cases.
module test_sha256_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] block_in = '0;
    logic [255:0] hash_in = '0;
    logic         done;
    logic [255:0] hash_out;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [255:0] IV = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam logic [255:0] ABC_DIG = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [255:0] TWO_DIG = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
    localparam logic [31:0] KT [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    sha256_core i_sha256_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .block_in (block_in),
        .hash_in  (hash_in),
        .done     (done),
        .hash_out (hash_out)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // Reference compression: full 64-entry schedule, textbook round order.
    function automatic logic [255:0] ref_compress(input logic [511:0] blk, input logic [255:0] hin);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] s0, s1, tmp1, tmp2;
        logic [255:0] r;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 64; i++) begin
            s0 = rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3);
            s1 = rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10);
            w[i] = w[i-16] + s0 + w[i-7] + s1;
        end
        for (int j = 0; j < 8; j++) v[j] = hin[255-32*j -: 32];
        for (int i = 0; i < 64; i++) begin
            tmp1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
                 + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KT[i] + w[i];
            tmp2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
                 + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            for (int j = 7; j > 0; j--) v[j] = v[j-1];
            v[4] = v[4] + tmp1;
            v[0] = tmp1 + tmp2;
        end
        for (int j = 0; j < 8; j++) r[255-32*j -: 32] = v[j] + hin[255-32*j -: 32];
        return r;
    endfunction

    function automatic logic [511:0] r512();
        logic [511:0] x;
        for (int i = 0; i < 16; i++) x[32*i +: 32] = $urandom();
        return x;
    endfunction

    function automatic logic [255:0] r256();
        logic [255:0] x;
        for (int i = 0; i < 8; i++) x[32*i +: 32] = $urandom();
        return x;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Launch one block now (at a falling edge) and wait for done.
    // With noisy set, data inputs and start are scrambled during the run.
    task automatic do_block(input logic [511:0] blk, input logic [255:0] hin, input bit noisy,
                            output logic [255:0] res, output int lat);
        block_in = blk;
        hash_in  = hin;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        if (noisy) begin
            block_in = r512();
            hash_in  = r256();
        end
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (noisy && !done) begin
                start    = 1'($urandom() % 2);
                block_in = r512();
                hash_in  = r256();
            end else begin
                start = 1'b0;
            end
        end
        res = hash_out;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [511:0] abc_blk, b1, b2, rb, rb2;
        logic [255:0] res, mid, rh, rh2;
        int lat;
        bit seen;
        void'($urandom(32'd7411));

        abc_blk = {32'h61626380, 448'd0, 32'h00000018};
        b1 = '0;
        for (int i = 0; i < 14; i++)
            for (int j = 0; j < 4; j++)
                b1[511-32*i-8*j -: 8] = 8'(8'h61 + i + j);
        b1[511-32*14 -: 32] = 32'h80000000;
        b2 = {480'd0, 32'h000001c0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8 reset done", 256'(done), 256'd0);
        check("R8 reset hash_out", hash_out, 256'd0);

        // R2: reference model agrees with the published vectors
        check("R2 model abc", ref_compress(abc_blk, IV), ABC_DIG);
        check("R3 model two-block", ref_compress(b2, ref_compress(b1, IV)), TWO_DIG);

        // R1 R2 R4: abc vector, word order and latency
        do_block(abc_blk, IV, 1'b0, res, lat);
        check("R1 R2 abc digest", res, ABC_DIG);
        check("R4 latency abc", 256'(lat), 256'd65);
        @(negedge clk);
        // R5: done is a one-cycle pulse
        check("R5 done pulse", 256'(done), 256'd0);
        repeat (5) @(negedge clk);
        // R6: result held while idle
        check("R6 hold hash_out", hash_out, ABC_DIG);

        // R3: two chained calls
        do_block(b1, IV, 1'b0, mid, lat);
        @(negedge clk);
        do_block(b2, mid, 1'b0, res, lat);
        check("R3 two-block digest", res, TWO_DIG);
        check("R4 latency two-block", 256'(lat), 256'd65);
        @(negedge clk);

        // R2 R7: random blocks with scrambled inputs and stray starts mid-run
        for (int n = 0; n < 6; n++) begin
            rb = r512();
            rh = r256();
            do_block(rb, rh, 1'b1, res, lat);
            check("R2 R7 random digest", res, ref_compress(rb, rh));
            check("R4 R7 latency random", 256'(lat), 256'd65);
            @(negedge clk);
        end

        // R9: back-to-back, second start in the done cycle
        rb  = r512(); rh  = r256();
        rb2 = r512(); rh2 = r256();
        do_block(rb, rh, 1'b0, res, lat);
        check("R9 first digest", res, ref_compress(rb, rh));
        do_block(rb2, rh2, 1'b0, res, lat);
        check("R9 second digest", res, ref_compress(rb2, rh2));
        check("R9 second latency", 256'(lat), 256'd65);
        @(negedge clk);

        // R8: reset in the middle of a run
        block_in = abc_blk;
        hash_in  = IV;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 mid-run reset hash_out", hash_out, 256'd0);
        seen = 1'b0;
        for (int c = 0; c < 80; c++) begin
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        check("R8 no done after reset", 256'(seen), 256'd0);
        do_block(abc_blk, IV, 1'b0, res, lat);
        check("R8 run after reset", res, ABC_DIG);
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule